// File: doc/BRIEF.md
# Multichannel Timestamp Record Packer

The packer collects, once per coarse clock period, the fine interpolation values and event flags of four timestamp channels. It joins them with a 48-bit free-running coarse count into one 64-bit record. A record is stored only when at least one channel flags an event. The count starts at zero when reset is released and advances once per clock, so a record carries the number of clock periods since reset.

Stored records wait in a FIFO that takes a whole 64-bit record per write and gives out one byte per read. Its output drives a byte-wide link with a valid/ready handshake, most significant byte first. If a record arrives while every slot is occupied, the record is discarded and a sticky overflow flag is raised. The flag stays set until reset, so a capture that lost data can be recognised afterwards.

Top module: `tag_record_packer`

## Requirements
- R1: While reset is held and right after it is released, `byte_valid` is 0 and `overflow` is 0.
- R2: A record is stored only in a cycle where at least one bit of `ch_evt` is 1. With no event, no bytes appear at the output.
- R3: Record bits 63:48 hold four 4-bit channel fields. Channel 3 uses bits 63:60 and channel 0 uses bits 51:48. In each field the top bit is the channel's event flag and the lower 3 bits are its fine value from `ch_fine`. Channel n's fine value is `ch_fine[3n+2:3n]`.
- R4: Record bits 47:0 hold the coarse count of the cycle in which the record was taken. That count is the number of rising clock edges since reset was released, before that cycle's edge.
- R5: Each record leaves as eight bytes, bits 63:56 first and bits 7:0 last. A byte is transferred on a rising edge where `byte_valid` and `byte_ready` are both 1.
- R6: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` stays 1 and `byte_data` stays unchanged.
- R7: With DEPTH records stored, an arriving record is discarded, `overflow` becomes 1 on the following cycle, and the stored records are unaffected.
- R8: Once set, `overflow` stays 1 until reset, even after the FIFO drains.
- R9: Records leave in the order they were taken. Events in consecutive cycles each produce a record, including while bytes are being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock (phase-0 domain) |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_fine | input | 12 | Fine values, 3 bits per channel, channel 0 lowest |
| ch_evt | input | 4 | Per-channel event flags for this period |
| byte_data | output | 8 | Current output byte |
| byte_valid | output | 1 | A byte is available |
| byte_ready | input | 1 | The consumer accepts the byte this cycle |
| overflow | output | 1 | Sticky: a record was discarded |

## Verification
The assertions assume that the consumer may hold `byte_ready` low for any number of cycles. They also assume that `ch_evt` and `ch_fine` are settled before each rising edge, with no relation between them and the output side. The stimulus changes every input only on falling edges. It alternates two kinds of runs: runs with the output stalled, which fill the FIFO to its limit and beyond, and runs drained with `byte_ready` held high. Events are also injected while a drain is under way.

// File: rtl/tag_record_packer.sv
module tag_record_packer #(
  parameter int NCH    = 4,
  parameter int FINE_W = 3,
  parameter int CNT_W  = 48,
  parameter int DEPTH  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*FINE_W-1:0] ch_fine,
  input  logic [NCH-1:0]        ch_evt,
  output logic [7:0]            byte_data,
  output logic                  byte_valid,
  input  logic                  byte_ready,
  output logic                  overflow
);
  localparam int FLD_W  = FINE_W + 1;
  localparam int REC_W  = NCH * FLD_W + CNT_W;
  localparam int NBYTES = REC_W / 8;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW     = $clog2(NBYTES);
  localparam int CW     = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] coarse;
  logic [REC_W-1:0] rec;
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [BW-1:0]    bidx;
  logic [CW-1:0]    fill;
  logic [REC_W-1:0] head;

  assign rec[CNT_W-1:0] = coarse;
  for (genvar g = 0; g < NCH; g++) begin : g_field
    assign rec[CNT_W+g*FLD_W +: FLD_W] = {ch_evt[g], ch_fine[g*FINE_W +: FINE_W]};
  end

  wire hit      = |ch_evt;
  wire has_room = fill < CW'(DEPTH);
  wire push     = hit && has_room;
  wire xfer     = byte_valid && byte_ready;
  wire pop      = xfer && (bidx == BW'(NBYTES - 1));

  assign byte_valid = fill != '0;
  assign head       = mem[rd_ptr];
  assign byte_data  = head[8*(NBYTES-1-int'(bidx)) +: 8];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse   <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      bidx     <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      coarse <= coarse + 1'b1;
      if (hit && !has_room) overflow <= 1'b1;
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (xfer) bidx <= pop ? '0 : bidx + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  a_r8_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && fill == CW'(DEPTH)) |=> (overflow && fill == $past(fill) - CW'($past(pop))));

  a_r2_no_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (fill <= $past(fill)));

  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  a_r5_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(bidx));
endmodule

// File: tb/tag_record_packer_tb.sv
`timescale 1ns/1ps
module tag_record_packer_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ch_fine = '0;
  logic [3:0]  ch_evt = '0;
  logic [7:0]  byte_data;
  logic        byte_valid;
  logic        byte_ready = 1'b0;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  logic [47:0] tb_cyc;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) tb_cyc <= '0;
    else        tb_cyc <= tb_cyc + 1'b1;

  tag_record_packer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_fine(ch_fine), .ch_evt(ch_evt),
    .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .overflow(overflow)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] e, input logic [11:0] f, input logic [47:0] c);
    logic [63:0] r;
    r[47:0] = c;
    for (int n = 0; n < 4; n++) r[48+4*n +: 4] = {e[n], f[3*n +: 3]};
    return r;
  endfunction

  task automatic fire(input logic [3:0] e, input logic [11:0] f, input bit stored);
    @(negedge clk);
    ch_evt  = e;
    ch_fine = f;
    if (e != 0 && stored) exp_q.push_back(mk(e, f, tb_cyc));
  endtask

  task automatic idle();
    @(negedge clk);
    ch_evt  = '0;
    ch_fine = '0;
  endtask

  task automatic drain(input string req);
    logic [63:0] acc = '0;
    int nb = 0;
    int guard = 0;
    @(negedge clk);
    byte_ready = 1'b1;
    while (exp_q.size() > 0 && guard < 2000) begin
      if (byte_valid) begin
        acc = {acc[55:0], byte_data};
        nb++;
        if (nb == 8) begin
          check(req, acc, exp_q.pop_front());
          nb = 0;
        end
      end
      guard++;
      if (exp_q.size() > 0) @(negedge clk);
    end
    check({req, " queue emptied"}, 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    byte_ready = 1'b0;
    check("R2 no bytes after drain", 64'(byte_valid), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    byte_ready = 1'b0;
    ch_evt = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(byte_valid), 64'd0);
    check("R1 overflow in reset", 64'(overflow), 64'd0);
    rst_n = 1'b1;
    exp_q.delete();
    @(negedge clk);
    check("R1 valid after reset", 64'(byte_valid), 64'd0);
    check("R1 overflow after reset", 64'(overflow), 64'd0);
  endtask

  task automatic t_idle_r2();
    byte_ready = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 idle gives no bytes", 64'(byte_valid), 64'd0);
    byte_ready = 1'b0;
  endtask

  task automatic t_layout_r3_r4_r5();
    fire(4'b1001, 12'b101_011_110_010, 1'b1);
    idle();
    drain("R3 R4 R5 layout ch3+ch0");
    fire(4'b0110, 12'b001_111_000_100, 1'b1);
    idle();
    drain("R3 R4 R5 layout ch2+ch1");
    fire(4'b1111, 12'hFFF, 1'b1);
    idle();
    drain("R3 all channels");
  endtask

  task automatic t_hold_r6();
    logic [7:0] first;
    fire(4'b0001, 12'h5A3, 1'b1);
    idle();
    @(negedge clk);
    first = byte_data;
    check("R5 first byte is bits 63:56", 64'(first), 64'(exp_q[0][63:56]));
    repeat (5) @(negedge clk);
    check("R6 valid held while stalled", 64'(byte_valid), 64'd1);
    check("R6 data held while stalled", 64'(byte_data), 64'(first));
    drain("R6 record after stall");
  endtask

  task automatic t_burst_r9();
    fire(4'b0001, 12'h001, 1'b1);
    fire(4'b0010, 12'h010, 1'b1);
    fire(4'b0100, 12'h100, 1'b1);
    fire(4'b0000, 12'hABC, 1'b1);
    fire(4'b1000, 12'h800, 1'b1);
    idle();
    drain("R9 back-to-back order");
    fire(4'b0011, 12'h123, 1'b1);
    idle();
    @(negedge clk);
    byte_ready = 1'b1;
    repeat (3) @(negedge clk);
    byte_ready = 1'b0;
    fire(4'b0100, 12'h456, 1'b1);
    fire(4'b1000, 12'h789, 1'b1);
    idle();
    begin
      logic [63:0] partial = exp_q[0];
      logic [63:0] acc = partial[63:40];
      int guard = 0;
      byte_ready = 1'b1;
      while (guard < 5) begin
        acc = {acc[55:0], byte_data};
        guard++;
        @(negedge clk);
      end
      check("R9 record drained across writes", acc, partial);
      void'(exp_q.pop_front());
      byte_ready = 1'b0;
    end
    drain("R9 writes during drain");
  endtask

  task automatic t_overflow_r7_r8();
    for (int i = 0; i < DEPTH; i++) fire(4'(i % 15 + 1), 12'(i * 37), 1'b1);
    idle();
    check("R7 no overflow at exactly full", 64'(overflow), 64'd0);
    fire(4'b1111, 12'hEEE, 1'b0);
    idle();
    check("R7 overflow set on drop", 64'(overflow), 64'd1);
    drain("R7 kept records intact");
    check("R8 overflow after drain", 64'(overflow), 64'd1);
    fire(4'b0101, 12'h333, 1'b1);
    idle();
    drain("R8 traffic after overflow");
    check("R8 overflow still set", 64'(overflow), 64'd1);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_idle_r2();
    t_layout_r3_r4_r5();
    t_hold_r6();
    t_burst_r9();
    t_overflow_r7_r8();
    do_reset();
    t_layout_r3_r4_r5();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule